// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives three complementary switch pairs (phases A, B and C) from one shared up/down timing counter. Each switching period runs the counter from zero up to the programmed period value and back down again. Every phase compares its own duty value against the counter, so all high-side pulses sit on the middle of the period. Dead time moves each switching edge away from the position that the duty value alone would set. This opens a guard gap in which neither switch of a pair conducts.

Configuration arrives through a plain register write port. Each write updates a shadow copy of one register. The shadow bank is copied into the active bank only at a reload, and each reload raises a sync pulse of programmable width. In single-update mode a reload happens once per period, at the start. In double-update mode a second reload happens at the mid-period turn-around. This lets the second half of a period use different values from the first half, which produces asymmetric patterns. A status output shows which half of the period is running.

Top module: `pwm3_center`

## Requirements
- R1: While reset is asserted, every switch output, `sync_pulse` and `half_cycle` are low. After reset is released, they stay low until the first rising clock edge. At that edge the first period starts and `sync_pulse` goes high.
- R2: With the mode bit clear (the reset value), exactly one sync pulse rises per period, in the first cycle of the period. A period lasts 2 × P clocks, where P is the active period value.
- R3: Every period start, seen as `half_cycle` falling, falls in a cycle where `sync_pulse` is high.
- R4: With the mode bit set, a second sync pulse rises in the first cycle of the second half of the period. The second half then uses values written during the first half.
- R5: Writes go to shadow registers only. Outputs keep the active values until the next reload, and the active values change only in a cycle where `sync_pulse` is high.
- R6: A sync pulse stays high for W + 1 clocks, where W is the sync-width register (reset value 39). This holds while W + 1 is shorter than half a period.
- R7: Let Dm = min(duty, P) and dt = dead time. In each half period the high output is on for max(0, Dm − dt) cycles. These are the last cycles of the first half and the first cycles of the second half.
- R8: The low output is on for max(0, P − Dm − dt) cycles per half period. These are the first cycles of the first half and the last cycles of the second half. The high and low outputs of one phase are never on together.
- R9: With zero dead time, the high and low outputs of a phase are exact complements, and their on-times add up to P in every half.
- R10: `half_cycle` is 0 for the first P cycles of a period and 1 for the remaining P cycles.
- R11: Register map, selected by `wr_addr`:
  - 0: period P. Written values below 2 are stored as 2. Reset value 100.
  - 1: dead time, 10 bits. Reset value 0.
  - 2: sync width W, 8 bits. Reset value 39.
  - 3, 4, 5: duty of phases A, B and C, 16 bits each. Reset value 0.
  - 6: mode, held in bit 0. 1 selects double update. This bit acts at once and is not shadowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Register write value |
| sync_pulse | output | 1 | High for W+1 clocks from each reload |
| half_cycle | output | 1 | 0 in the first half of a period, 1 in the second |
| pwm_hi | output | 3 | High-side switch outputs, bit 0 = phase A |
| pwm_lo | output | 3 | Low-side switch outputs, bit 0 = phase A |

## Verification
The hardest case to reach from the ports is the asymmetric period in double-update mode. That case needs a write that lands after the start-of-period reload but before the mid-period reload. Only then do the two halves of one period carry different duty values. The bench locks onto the period start by watching `half_cycle` fall. It then issues the write at a fixed cycle offset inside the first half, while recording every output cycle of that period. The same aligned write in single-update mode shows that the value is held back until the following period.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int CNT_W   = 16;   // counter, period and duty width
  localparam int DT_W    = 10;   // dead-time width
  localparam int SW_W    = 8;    // sync-width register width
  localparam int NPH     = 3;    // number of phases
  localparam int AW      = 3;    // register address width
  localparam int DW      = 16;   // write data width
  localparam int MIN_PER = 2;    // smallest stored period

  localparam int A_PERIOD = 0;
  localparam int A_DEAD   = 1;
  localparam int A_SWIDTH = 2;
  localparam int A_DUTY0  = 3;
  localparam int A_MODE   = A_DUTY0 + NPH;

  typedef struct packed {
    logic [CNT_W-1:0]          period;
    logic [DT_W-1:0]           dead;
    logic [SW_W-1:0]           swidth;
    logic [NPH-1:0][CNT_W-1:0] duty;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter logic [CNT_W-1:0] PER_RST = 100,
  parameter logic [SW_W-1:0]  SW_RST  = 39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             load,
  output pwm_cfg_t         act,
  output logic [CNT_W-1:0] shd_period,
  output logic             dbl
);
  localparam pwm_cfg_t RST_CFG = '{period: PER_RST, dead: '0, swidth: SW_RST, duty: '0};

  pwm_cfg_t shd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= RST_CFG;
      act <= RST_CFG;
      dbl <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_addr == AW'(A_PERIOD))
          shd.period <= (wr_data < DW'(MIN_PER)) ? CNT_W'(MIN_PER) : wr_data[CNT_W-1:0];
        if (wr_addr == AW'(A_DEAD))
          shd.dead <= wr_data[DT_W-1:0];
        if (wr_addr == AW'(A_SWIDTH))
          shd.swidth <= wr_data[SW_W-1:0];
        for (int i = 0; i < NPH; i++)
          if (wr_addr == AW'(A_DUTY0 + i))
            shd.duty[i] <= wr_data[CNT_W-1:0];
        if (wr_addr == AW'(A_MODE))
          dbl <= wr_data[0];
      end
      if (load)
        act <= shd;
    end
  end

  assign shd_period = shd.period;
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
  import pwm3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl,
  input  logic [CNT_W-1:0] act_period,
  input  logic [CNT_W-1:0] shd_period,
  input  logic [SW_W-1:0]  act_swidth,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic             run,
  output logic             load,
  output logic             sync_pulse
);
  logic [CNT_W:0]   cnt_inc;
  logic             at_top, at_bot, mid_ld;
  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_up;
  logic [SW_W-1:0]  scnt;
  logic             sync_q;

  always_comb begin
    cnt_inc = {1'b0, cnt} + 1'b1;
    at_top  = run && up && (cnt_inc >= {1'b0, act_period});
    at_bot  = !up && (cnt <= CNT_W'(1));
    mid_ld  = at_top && dbl;
    load    = at_bot || mid_ld;
    if (at_bot) begin
      nxt_cnt = '0;
      nxt_up  = 1'b1;
    end else if (at_top) begin
      nxt_cnt = mid_ld ? shd_period : act_period;
      nxt_up  = 1'b0;
    end else begin
      nxt_cnt = up ? cnt_inc[CNT_W-1:0] : cnt - 1'b1;
      nxt_up  = up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      up     <= 1'b0;
      run    <= 1'b0;
      scnt   <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt <= nxt_cnt;
      up  <= nxt_up;
      run <= 1'b1;
      if (load) begin
        sync_q <= 1'b1;
        scnt   <= '0;
      end else if (sync_q) begin
        if (scnt == act_swidth) sync_q <= 1'b0;
        else                    scnt   <= scnt + 1'b1;
      end
    end
  end

  assign sync_pulse = sync_q;
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
  import pwm3_pkg::*;
(
  input  logic             run,
  input  logic             up,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [DT_W-1:0]  dead,
  input  logic [CNT_W-1:0] duty,
  output logic             hi,
  output logic             lo
);
  logic [CNT_W-1:0] q, dm, dt, h, rest, l;

  always_comb begin
    q    = up ? cnt : cnt - 1'b1;           // position within the half, 0..P-1
    dm   = (duty > period) ? period : duty;
    dt   = CNT_W'(dead);
    h    = (dm > dt) ? dm - dt : '0;
    rest = period - dm;
    l    = (rest > dt) ? rest - dt : '0;
    hi   = run && (q >= period - h);
    lo   = run && (q < l);
  end
endmodule

// File: rtl/pwm3_center.sv
module pwm3_center
  import pwm3_pkg::*;
#(
  parameter logic [CNT_W-1:0] PER_RST = 100,
  parameter logic [SW_W-1:0]  SW_RST  = 39
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           sync_pulse,
  output logic           half_cycle,
  output logic [NPH-1:0] pwm_hi,
  output logic [NPH-1:0] pwm_lo
);
  pwm_cfg_t         act_cfg;
  logic [CNT_W-1:0] shd_period;
  logic             dbl, load, run, up;
  logic [CNT_W-1:0] cnt;

  pwm3_regs #(.PER_RST(PER_RST), .SW_RST(SW_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .act(act_cfg), .shd_period(shd_period), .dbl(dbl)
  );

  pwm3_timer u_timer (
    .clk(clk), .rst_n(rst_n), .dbl(dbl),
    .act_period(act_cfg.period), .shd_period(shd_period), .act_swidth(act_cfg.swidth),
    .cnt(cnt), .up(up), .run(run), .load(load), .sync_pulse(sync_pulse)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    pwm3_phase u_ph (
      .run(run), .up(up), .cnt(cnt),
      .period(act_cfg.period), .dead(act_cfg.dead), .duty(act_cfg.duty[p]),
      .hi(pwm_hi[p]), .lo(pwm_lo[p])
    );
  end

  assign half_cycle = run & ~up;
endmodule

// File: rtl/pwm3_center_chk.sv
module pwm3_center_chk
  import pwm3_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           dbl,
  input logic           sync_pulse,
  input logic           half_cycle,
  input logic [NPH-1:0] pwm_hi,
  input logic [NPH-1:0] pwm_lo,
  input pwm_cfg_t       act
);
  always @(negedge clk) begin
    if (!rst_n)
      assert_reset_quiet_R1: assert (pwm_hi == '0 && pwm_lo == '0 && !sync_pulse && !half_cycle)
        else $error("outputs active during reset");
  end

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_hi & pwm_lo) == '0);

  assert_start_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(half_cycle) |-> sync_pulse);

  assert_mid_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(half_cycle) && $past(dbl)) |-> sync_pulse);

  assert_single_no_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(half_cycle) && !$past(dbl)) |-> !$rose(sync_pulse));

  assert_reload_at_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> sync_pulse);
endmodule

bind pwm3_center pwm3_center_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbl(dbl), .sync_pulse(sync_pulse),
  .half_cycle(half_cycle), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .act(act_cfg)
);

// File: tb/pwm3_center_bench.sv
`timescale 1ns/1ps
module pwm3_center_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sync_pulse, half_cycle;
  logic [2:0]  pwm_hi, pwm_lo;

  int checks = 0;
  int errors = 0;

  logic [2:0] cap_hi [512];
  logic [2:0] cap_lo [512];
  logic       cap_sync [512];
  int         cap_len, cap_n1;

  always #4 clk = ~clk;

  pwm3_center u_pwm3_center (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_pulse(sync_pulse), .half_cycle(half_cycle), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start();
    logic prev;
    bit   found;
    prev  = half_cycle;
    found = 1'b0;
    while (!found) begin
      @(negedge clk);
      if (prev && !half_cycle) found = 1'b1;
      prev = half_cycle;
    end
  endtask

  // Record one full period from its first cycle; optionally write at offset at_k.
  task automatic capture(input bit w, input int a, input int d, input int at_k);
    bit seen2, fin;
    wait_start();
    cap_len = 0; cap_n1 = 0; seen2 = 1'b0; fin = 1'b0;
    while (!fin) begin
      cap_hi[cap_len]   = pwm_hi;
      cap_lo[cap_len]   = pwm_lo;
      cap_sync[cap_len] = sync_pulse;
      if (half_cycle) seen2 = 1'b1;
      else if (!seen2) cap_n1++;
      if (w && cap_len == at_k) begin
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
      end
      cap_len++;
      @(negedge clk);
      wr_en = 1'b0;
      if (seen2 && !half_cycle) fin = 1'b1;
      if (cap_len >= 512) fin = 1'b1;
    end
  endtask

  function automatic int on_hi(input int p, input int d, input int dt);
    int dm = (d > p) ? p : d;
    return (dm > dt) ? dm - dt : 0;
  endfunction

  function automatic int on_lo(input int p, input int d, input int dt);
    int dm = (d > p) ? p : d;
    return (p - dm > dt) ? p - dm - dt : 0;
  endfunction

  function automatic int sync_width();
    int n = 0;
    while (n < cap_len && cap_sync[n]) n++;
    return n;
  endfunction

  function automatic int sync_rises();
    int n = 0;
    for (int k = 0; k < cap_len; k++)
      if (cap_sync[k] && (k == 0 || !cap_sync[k-1])) n++;
    return n;
  endfunction

  task automatic check_phase(input string req, input int ph, input int p1, input int p2,
                             input int d1, input int d2, input int dt);
    int h1, l1, h2, l2, bad, nh, nl;
    h1 = on_hi(p1, d1, dt); l1 = on_lo(p1, d1, dt);
    h2 = on_hi(p2, d2, dt); l2 = on_lo(p2, d2, dt);
    bad = 0; nh = 0; nl = 0;
    for (int k = 0; k < p1; k++) begin
      if (cap_hi[k][ph] !== (k >= p1 - h1)) bad++;
      if (cap_lo[k][ph] !== (k < l1)) bad++;
      if (cap_hi[k][ph] === 1'b1) nh++;
      if (cap_lo[k][ph] === 1'b1) nl++;
    end
    for (int k = 0; k < p2; k++) begin
      if (cap_hi[p1+k][ph] !== (k < h2)) bad++;
      if (cap_lo[p1+k][ph] !== (k >= p2 - l2)) bad++;
      if (cap_hi[p1+k][ph] === 1'b1) nh++;
      if (cap_lo[p1+k][ph] === 1'b1) nl++;
    end
    chk(req, $sformatf("phase %0d pattern mismatches", ph), bad, 0);
    chk(req, $sformatf("phase %0d high cycles", ph), nh, h1 + h2);
    chk(req, $sformatf("phase %0d low cycles", ph), nl, l1 + l2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "hi in reset", int'(pwm_hi), 0);
    chk("R1", "lo in reset", int'(pwm_lo), 0);
    chk("R1", "sync in reset", int'(sync_pulse), 0);
    rst_n = 1'b1;
    #1;
    chk("R1", "sync before first edge", int'(sync_pulse), 0);
    @(negedge clk);
    chk("R1", "sync after first edge", int'(sync_pulse), 1);
    chk("R1", "half after first edge", int'(half_cycle), 0);
  endtask

  task automatic t_defaults();
    capture(1'b0, 0, 0, 0);
    chk("R10", "first half length", cap_n1, 100);
    chk("R2", "period length", cap_len, 200);
    chk("R6", "default sync width", sync_width(), 40);
    chk("R2", "sync rises per period", sync_rises(), 1);
    check_phase("R8", 0, 100, 100, 0, 0, 0);
  endtask

  task automatic t_registers();
    wr_reg(0, 20); wr_reg(2, 4); wr_reg(1, 0);
    wr_reg(3, 5); wr_reg(4, 20); wr_reg(5, 30);
    capture(1'b0, 0, 0, 0);
    capture(1'b0, 0, 0, 0);
    chk("R11", "first half length", cap_n1, 20);
    chk("R10", "second half length", cap_len - cap_n1, 20);
    chk("R6", "sync width 4", sync_width(), 5);
    check_phase("R9", 0, 20, 20, 5, 5, 0);
    check_phase("R9", 1, 20, 20, 20, 20, 0);
    check_phase("R7", 2, 20, 20, 30, 30, 0);
  endtask

  task automatic t_dead();
    int ovl;
    wr_reg(1, 3); wr_reg(3, 10); wr_reg(4, 2); wr_reg(5, 19);
    capture(1'b0, 0, 0, 0);
    capture(1'b0, 0, 0, 0);
    check_phase("R7", 0, 20, 20, 10, 10, 3);
    check_phase("R8", 1, 20, 20, 2, 2, 3);
    check_phase("R8", 2, 20, 20, 19, 19, 3);
    ovl = 0;
    for (int k = 0; k < cap_len; k++) if ((cap_hi[k] & cap_lo[k]) != 3'b000) ovl++;
    chk("R8", "overlap cycles", ovl, 0);
  endtask

  task automatic t_single_hold();
    wr_reg(1, 0); wr_reg(3, 4);
    capture(1'b0, 0, 0, 0);
    capture(1'b1, 3, 12, 2);
    check_phase("R5", 0, 20, 20, 4, 4, 0);
    chk("R2", "single mode rises", sync_rises(), 1);
    capture(1'b0, 0, 0, 0);
    check_phase("R5", 0, 20, 20, 12, 12, 0);
  endtask

  task automatic t_double();
    wr_reg(6, 1); wr_reg(3, 4);
    capture(1'b0, 0, 0, 0);
    capture(1'b1, 3, 12, 2);
    check_phase("R4", 0, 20, 20, 4, 12, 0);
    chk("R4", "double mode rises", sync_rises(), 2);
    chk("R4", "sync at midpoint", int'(cap_sync[20]), 1);
    chk("R4", "sync low before midpoint", int'(cap_sync[19]), 0);
  endtask

  task automatic t_clamp();
    wr_reg(6, 0); wr_reg(2, 0); wr_reg(0, 1);
    wr_reg(3, 1); wr_reg(4, 0); wr_reg(5, 2);
    capture(1'b0, 0, 0, 0);
    capture(1'b0, 0, 0, 0);
    chk("R11", "clamped first half", cap_n1, 2);
    chk("R11", "clamped period", cap_len, 4);
    chk("R6", "sync width 0", sync_width(), 1);
    check_phase("R9", 0, 2, 2, 1, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_defaults();
    t_registers();
    t_dead();
    t_single_hold();
    t_double();
    t_clamp();
    summary();
    $finish;
  end
endmodule